// File: doc/BRIEF.md
# Delayed Transaction Completion Tracker

This block sits inside a bus bridge and follows a single delayed transaction from the moment an initiator first asks for it until the initiator collects the answer. The first request is captured and forwarded to the target side, and the initiator is told to retry. When the target side reports a result, the tracker holds it until the initiator repeats the same address and command. That retry is then answered with a normal completion, with all-ones read data, or with a target abort. Which of these applies depends on the target-side outcome and on a configurable abort policy.

Once the result is held, a discard timer starts. Its length is chosen by a configuration bit. If the initiator does not return before the timer runs out, the held transaction is dropped, a one-cycle discard pulse is emitted and the tracker becomes free again. A separate path raises a one-cycle system-error pulse when a posted write master-aborts, provided the abort policy and the error enable both allow it. The two configuration bits live in a small register that reset clears and that a load strobe writes.

Top module: `dly_txn_tracker`

## Requirements
- R1: A request strobe seen while idle is captured. The next cycle, `tgt_issue` is high and `tgt_addr`/`tgt_cmd` carry the captured address and command.
- R2: Every `req_valid` cycle gets exactly one response: `rsp_valid` is high in the following cycle, and only then. The response codes are 0 = retry, 1 = normal completion, 2 = target abort.
- R3: A request strobe that arrives while the target result is outstanding gets a retry (code 0) and leaves the stored request unchanged. So does a strobe that arrives while a result is held but differs from the stored request in address or command.
- R4: A matching retry after a successful target read returns code 1 with the data the target supplied.
- R5: With the abort-mode bit at 0, a master-aborted transaction is answered with code 1. A read returns FFFFFFFFh; a write (command bit 0 set) returns data 0.
- R6: With the abort-mode bit at 1, a master-aborted transaction is answered with code 2 (target abort).
- R7: The discard timer starts when the result is held, not when the request is captured. A matching retry in the last cycle of the window is still delivered, with no discard.
- R8: When the timer expires with no matching retry, `discard_pulse` is high for exactly one cycle, the held result is dropped, and the next request is captured as a new transaction.
- R9: With the timeout-select bit at 0 the held result lasts 2^15 cycles; with it at 1 it lasts 2^10 cycles.
- R10: `serr_pulse` is high in the cycle after `pw_mabort` only when the abort-mode bit is 1 and `serr_en` is 1. It is never raised when the abort-mode bit is 0.
- R11: Reset clears both configuration bits to 0 (abort-mode 0, long timeout) and drives every output low. `cfg_load` writes both bits.
- R12: A request in the cycle right after a delivery gets a retry and is not captured: `tgt_issue` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Writes the two configuration bits |
| cfg_abort_in | input | 1 | Abort-mode value to load |
| cfg_fast_in | input | 1 | Timeout-select value to load (1 = short) |
| serr_en | input | 1 | System-error reporting enable |
| req_valid | input | 1 | Initiator request or retry strobe |
| req_addr | input | ADDR_W | Request address |
| req_cmd | input | CMD_W | Request command; bit 0 set = write |
| tgt_done | input | 1 | Target-side result strobe |
| tgt_rdata | input | DATA_W | Target read data |
| tgt_mabort | input | 1 | Target side ended in master abort |
| pw_mabort | input | 1 | A posted write master-aborted |
| tgt_issue | output | 1 | Forwarded request outstanding |
| tgt_addr | output | ADDR_W | Forwarded address |
| tgt_cmd | output | CMD_W | Forwarded command |
| rsp_valid | output | 1 | Response valid |
| rsp_kind | output | 2 | 0 retry, 1 completion, 2 target abort |
| rsp_data | output | DATA_W | Response read data |
| discard_pulse | output | 1 | Held result dropped on timer expiry |
| serr_pulse | output | 1 | System-error indication |

## Verification
A matching retry and the expiry of the discard timer can land in the same cycle. The bench provokes this by strobing the retry exactly 2^10 cycles after the result is taken, which is the final cycle of the short window. It expects a normal completion with the held data and no discard pulse, because delivery takes precedence. The one-cycle-later case is also driven: there the discard pulse must appear and the same request must be treated as new.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PEND  = 2'd1,
    ST_READY = 2'd2,
    ST_DELIV = 2'd3
  } trk_state_e;

  typedef enum logic [1:0] {
    RSP_RETRY  = 2'd0,
    RSP_DONE   = 2'd1,
    RSP_TABORT = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/dtt_cfg_regs.sv
module dtt_cfg_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic abort_in,
  input  logic fast_in,
  output logic abort_mode,
  output logic fast_sel
);
  logic abort_q, abort_d;
  logic fast_q, fast_d;

  always_comb begin
    abort_d = abort_q;
    fast_d  = fast_q;
    if (load) begin
      abort_d = abort_in;
      fast_d  = fast_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q <= 1'b0;
      fast_q  <= 1'b0;
    end else begin
      abort_q <= abort_d;
      fast_q  <= fast_d;
    end
  end

  assign abort_mode = abort_q;
  assign fast_sel   = fast_q;
endmodule

// File: rtl/dtt_txn_store.sv
module dtt_txn_store #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_req,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CMD_W-1:0]  in_cmd,
  input  logic              cap_res,
  input  logic [DATA_W-1:0] in_rdata,
  input  logic              in_mabort,
  output logic [ADDR_W-1:0] st_addr,
  output logic [CMD_W-1:0]  st_cmd,
  output logic [DATA_W-1:0] st_rdata,
  output logic              st_mabort,
  output logic              hit
);
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] rdata_q;
  logic              mab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
    end else if (cap_req) begin
      addr_q <= in_addr;
      cmd_q  <= in_cmd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      mab_q   <= 1'b0;
    end else if (cap_res) begin
      rdata_q <= in_rdata;
      mab_q   <= in_mabort;
    end
  end

  assign hit       = (in_addr == addr_q) && (in_cmd == cmd_q);
  assign st_addr   = addr_q;
  assign st_cmd    = cmd_q;
  assign st_rdata  = rdata_q;
  assign st_mabort = mab_q;
endmodule

// File: rtl/dtt_discard_timer.sv
module dtt_discard_timer #(
  parameter int LONG_EXP  = 15,
  parameter int SHORT_EXP = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  input  logic fast_sel,
  output logic expire
);
  localparam int CW = LONG_EXP;
  localparam logic [CW-1:0] LAST_LONG  = CW'((64'd1 << LONG_EXP) - 64'd1);
  localparam logic [CW-1:0] LAST_SHORT = CW'((64'd1 << SHORT_EXP) - 64'd1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last;

  assign last   = fast_sel ? LAST_SHORT : LAST_LONG;
  assign expire = run && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || clear || expire) cnt_d = '0;
    else                         cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dtt_resp_encode.sv
module dtt_resp_encode
  import dtt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              deliver,
  input  logic              is_write,
  input  logic              mabort,
  input  logic              abort_mode,
  input  logic [DATA_W-1:0] held_data,
  output rsp_kind_e         kind,
  output logic [DATA_W-1:0] data
);
  always_comb begin
    kind = RSP_RETRY;
    data = '0;
    if (deliver) begin
      if (!mabort) begin
        kind = RSP_DONE;
        data = is_write ? '0 : held_data;
      end else if (abort_mode) begin
        kind = RSP_TABORT;
      end else begin
        kind = RSP_DONE;
        data = is_write ? '0 : '1;
      end
    end
  end
endmodule

// File: rtl/dly_txn_tracker.sv
module dly_txn_tracker
  import dtt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CMD_W     = 4,
  parameter int LONG_EXP  = 15,
  parameter int SHORT_EXP = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic              cfg_abort_in,
  input  logic              cfg_fast_in,
  input  logic              serr_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic              tgt_done,
  input  logic [DATA_W-1:0] tgt_rdata,
  input  logic              tgt_mabort,
  input  logic              pw_mabort,
  output logic              tgt_issue,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [CMD_W-1:0]  tgt_cmd,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [DATA_W-1:0] rsp_data,
  output logic              discard_pulse,
  output logic              serr_pulse
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic cfg_abort, cfg_fast;

  dtt_cfg_regs u_cfg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (cfg_load),
    .abort_in   (cfg_abort_in),
    .fast_in    (cfg_fast_in),
    .abort_mode (cfg_abort),
    .fast_sel   (cfg_fast)
  );

  trk_state_e st_q, st_d;
  logic cap_req, cap_res, deliver, discard;
  logic hit, expire;
  logic [DATA_W-1:0] held_data;
  logic held_mab;

  dtt_txn_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CMD_W  (CMD_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cap_req   (cap_req),
    .in_addr   (req_addr),
    .in_cmd    (req_cmd),
    .cap_res   (cap_res),
    .in_rdata  (tgt_rdata),
    .in_mabort (tgt_mabort),
    .st_addr   (tgt_addr),
    .st_cmd    (tgt_cmd),
    .st_rdata  (held_data),
    .st_mabort (held_mab),
    .hit       (hit)
  );

  dtt_discard_timer #(
    .LONG_EXP  (LONG_EXP),
    .SHORT_EXP (SHORT_EXP)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (st_q == ST_READY),
    .clear    (deliver),
    .fast_sel (cfg_fast),
    .expire   (expire)
  );

  // next-state logic: a matching retry wins over a same-cycle expiry
  always_comb begin
    st_d    = st_q;
    cap_req = 1'b0;
    cap_res = 1'b0;
    deliver = 1'b0;
    discard = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_req = 1'b1;
          st_d    = ST_PEND;
        end
      end
      ST_PEND: begin
        if (tgt_done) begin
          cap_res = 1'b1;
          st_d    = ST_READY;
        end
      end
      ST_READY: begin
        if (req_valid && hit) begin
          deliver = 1'b1;
          st_d    = ST_DELIV;
        end else if (expire) begin
          discard = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      ST_DELIV: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) st_q <= ST_IDLE;
    else             st_q <= st_d;
  end

  rsp_kind_e         enc_kind;
  logic [DATA_W-1:0] enc_data;

  dtt_resp_encode #(
    .DATA_W (DATA_W)
  ) u_enc (
    .deliver    (deliver),
    .is_write   (tgt_cmd[0]),
    .mabort     (held_mab),
    .abort_mode (cfg_abort),
    .held_data  (held_data),
    .kind       (enc_kind),
    .data       (enc_data)
  );

  logic              rsp_valid_q;
  rsp_kind_e         rsp_kind_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              discard_q;
  logic              serr_q;
  logic              serr_d;

  assign serr_d = pw_mabort && cfg_abort && serr_en;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid_q <= 1'b0;
      discard_q   <= 1'b0;
      serr_q      <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid;
      discard_q   <= discard;
      serr_q      <= serr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_kind_q <= RSP_RETRY;
      rsp_data_q <= '0;
    end else if (req_valid) begin
      rsp_kind_q <= enc_kind;
      rsp_data_q <= enc_data;
    end
  end

  assign tgt_issue     = (st_q == ST_PEND);
  assign rsp_valid     = rsp_valid_q;
  assign rsp_kind      = rsp_kind_q;
  assign rsp_data      = rsp_valid_q ? rsp_data_q : '0;
  assign discard_pulse = discard_q;
  assign serr_pulse    = serr_q;
endmodule

// File: rtl/dtt_tracker_chk.sv
module dtt_tracker_chk #(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic [1:0]        rsp_kind,
  input logic              cfg_abort,
  input logic              serr_en,
  input logic              pw_mabort,
  input logic              serr_pulse,
  input logic              discard_pulse,
  input logic              tgt_issue,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic [CMD_W-1:0]  tgt_cmd
);
  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  assert_tabort_needs_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'd2) |-> $past(cfg_abort));

  assert_serr_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pulse |-> $past(pw_mabort && cfg_abort && serr_en));

  assert_discard_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    discard_pulse |=> !discard_pulse);

  assert_discard_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    discard_pulse |-> !tgt_issue);

  assert_fwd_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_issue && $past(tgt_issue)) |-> ($stable(tgt_addr) && $stable(tgt_cmd)));
endmodule

bind dly_txn_tracker dtt_tracker_chk #(
  .ADDR_W (ADDR_W),
  .CMD_W  (CMD_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .rsp_valid     (rsp_valid),
  .rsp_kind      (rsp_kind),
  .cfg_abort     (cfg_abort),
  .serr_en       (serr_en),
  .pw_mabort     (pw_mabort),
  .serr_pulse    (serr_pulse),
  .discard_pulse (discard_pulse),
  .tgt_issue     (tgt_issue),
  .tgt_addr      (tgt_addr),
  .tgt_cmd       (tgt_cmd)
);

// File: tb/tb_dly_txn_tracker.sv
module tb_dly_txn_tracker;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cfg_load, cfg_abort_in, cfg_fast_in, serr_en;
  logic req_valid, tgt_done, tgt_mabort, pw_mabort;
  logic [AW-1:0] req_addr;
  logic [CW-1:0] req_cmd;
  logic [DW-1:0] tgt_rdata;
  logic tgt_issue, rsp_valid, discard_pulse, serr_pulse;
  logic [AW-1:0] tgt_addr;
  logic [CW-1:0] tgt_cmd;
  logic [1:0]    rsp_kind;
  logic [DW-1:0] rsp_data;

  dly_txn_tracker dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_abort_in(cfg_abort_in),
    .cfg_fast_in(cfg_fast_in), .serr_en(serr_en), .req_valid(req_valid),
    .req_addr(req_addr), .req_cmd(req_cmd), .tgt_done(tgt_done),
    .tgt_rdata(tgt_rdata), .tgt_mabort(tgt_mabort), .pw_mabort(pw_mabort),
    .tgt_issue(tgt_issue), .tgt_addr(tgt_addr), .tgt_cmd(tgt_cmd),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
    .discard_pulse(discard_pulse), .serr_pulse(serr_pulse)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit mon_en  = 1'b0;

  typedef struct {
    logic [1:0]    kind;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (mon_en && rsp_valid) begin
      n_tests++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected response: actual kind %0d expected none", rsp_kind);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (rsp_kind !== e.kind || rsp_data !== e.data) begin
          n_fail++;
          $display("FAIL %s: actual kind %0d data %h expected kind %0d data %h",
                   e.tag, rsp_kind, rsp_data, e.kind, e.data);
        end
      end
    end
  end

  task automatic send_req(logic [AW-1:0] a, logic [CW-1:0] c,
                          logic [1:0] k, logic [DW-1:0] d, string tag);
    exp_t e;
    e.kind = k; e.data = d; e.tag = tag;
    sb_q.push_back(e);
    req_valid = 1'b1; req_addr = a; req_cmd = c;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic tgt_finish(logic [DW-1:0] d, logic mab);
    tgt_done = 1'b1; tgt_rdata = d; tgt_mabort = mab;
    @(negedge clk);
    tgt_done = 1'b0;
  endtask

  task automatic load_cfg(logic ab, logic fs);
    cfg_load = 1'b1; cfg_abort_in = ab; cfg_fast_in = fs;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic pw_pulse();
    pw_mabort = 1'b1;
    @(negedge clk);
    pw_mabort = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_abort_in = 1'b0; cfg_fast_in = 1'b0;
    serr_en = 1'b0; req_valid = 1'b0; tgt_done = 1'b0; tgt_mabort = 1'b0;
    pw_mabort = 1'b0; req_addr = '0; req_cmd = '0; tgt_rdata = '0;
    repeat (4) @(negedge clk);
    chk("R11 rsp_valid in reset", DW'(rsp_valid), 0);
    chk("R11 tgt_issue in reset", DW'(tgt_issue), 0);
    chk("R11 discard in reset",   DW'(discard_pulse), 0);
    chk("R11 serr in reset",      DW'(serr_pulse), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    // R1 capture, R3 mismatch, R4 delivery, R12 busy after delivery
    send_req(32'h0000_1000, 4'h6, 2'd0, 0, "R1 first request");
    chk("R1 tgt_issue", DW'(tgt_issue), 1);
    chk("R1 tgt_addr", tgt_addr, 32'h0000_1000);
    chk("R1 tgt_cmd", DW'(tgt_cmd), 6);
    send_req(32'h0000_2000, 4'h6, 2'd0, 0, "R3 request while pending");
    chk("R3 addr kept while pending", tgt_addr, 32'h0000_1000);
    repeat (5) @(negedge clk);
    tgt_finish(32'h1234_5678, 1'b0);
    send_req(32'h0000_2000, 4'h6, 2'd0, 0, "R3 address mismatch");
    send_req(32'h0000_1000, 4'h7, 2'd0, 0, "R3 command mismatch");
    send_req(32'h0000_1000, 4'h6, 2'd1, 32'h1234_5678, "R4 matching retry");
    send_req(32'h0000_3000, 4'h6, 2'd0, 0, "R12 request right after delivery");
    chk("R12 not captured", DW'(tgt_issue), 0);
    @(negedge clk);

    // R5 with default abort mode (R11)
    send_req(32'h0000_4000, 4'h6, 2'd0, 0, "R5 read capture");
    tgt_finish(32'h0BAD_0BAD, 1'b1);
    send_req(32'h0000_4000, 4'h6, 2'd1, 32'hFFFF_FFFF, "R5 R11 read master abort");
    @(negedge clk);
    send_req(32'h0000_4400, 4'h7, 2'd0, 0, "R5 write capture");
    tgt_finish(32'h5555_5555, 1'b1);
    send_req(32'h0000_4400, 4'h7, 2'd1, 0, "R5 write master abort");
    @(negedge clk);

    // R9 long window with default select (R11)
    send_req(32'h0000_5000, 4'h6, 2'd0, 0, "R9 long capture");
    tgt_finish(32'hAAAA_0001, 1'b0);
    repeat (32767) @(negedge clk);
    chk("R9 no discard before 2^15", DW'(discard_pulse), 0);
    @(negedge clk);
    chk("R9 R8 discard after 2^15", DW'(discard_pulse), 1);
    send_req(32'h0000_5000, 4'h6, 2'd0, 0, "R8 request after discard is new");
    chk("R8 recaptured", DW'(tgt_issue), 1);
    tgt_finish(32'hAAAA_0002, 1'b0);
    send_req(32'h0000_5000, 4'h6, 2'd1, 32'hAAAA_0002, "R8 fresh result");
    @(negedge clk);

    // R6 target abort, short window
    load_cfg(1'b1, 1'b1);
    send_req(32'h0000_6000, 4'h6, 2'd0, 0, "R6 capture");
    tgt_finish(32'h0, 1'b1);
    send_req(32'h0000_6000, 4'h6, 2'd2, 0, "R6 target abort");
    @(negedge clk);

    // R7 timer starts at ready; retry on the final cycle is delivered
    send_req(32'h0000_7000, 4'h6, 2'd0, 0, "R7 capture");
    repeat (40) @(negedge clk);
    tgt_finish(32'hCAFE_0007, 1'b0);
    repeat (1023) @(negedge clk);
    send_req(32'h0000_7000, 4'h6, 2'd1, 32'hCAFE_0007, "R7 retry on last cycle");
    chk("R7 no discard when delivered", DW'(discard_pulse), 0);
    @(negedge clk);

    // R8/R9 short window discard
    send_req(32'h0000_8000, 4'h6, 2'd0, 0, "R9 short capture");
    tgt_finish(32'hBEEF_0008, 1'b0);
    repeat (1023) @(negedge clk);
    chk("R9 no discard before 2^10", DW'(discard_pulse), 0);
    @(negedge clk);
    chk("R9 discard after 2^10", DW'(discard_pulse), 1);
    @(negedge clk);
    chk("R8 discard one cycle", DW'(discard_pulse), 0);
    send_req(32'h0000_8000, 4'h6, 2'd0, 0, "R8 retry after discard");
    chk("R8 recaptured short", DW'(tgt_issue), 1);
    tgt_finish(32'hBEEF_0009, 1'b0);
    send_req(32'h0000_8000, 4'h6, 2'd1, 32'hBEEF_0009, "R8 new result");
    @(negedge clk);

    // R10 system error gating
    serr_en = 1'b0;
    pw_pulse();
    chk("R10 serr disabled", DW'(serr_pulse), 0);
    serr_en = 1'b1;
    pw_pulse();
    chk("R10 serr raised", DW'(serr_pulse), 1);
    load_cfg(1'b0, 1'b1);
    pw_pulse();
    chk("R10 serr with abort mode 0", DW'(serr_pulse), 0);

    repeat (3) @(negedge clk);
    chk("R2 all responses seen", DW'(sb_q.size()), 0);
    finish_run();
  end
endmodule